// File: doc/BRIEF.md
# Virtual-Supervisor Interrupt Injection and Pending Merge

This block holds the three pending bits that a hypervisor injects into a guest running at virtual-supervisor level: software, timer and external. It also builds the VS-level part of the combined pending view that the machine and hypervisor pending registers show. The combined view merges the injected bits with a guest external interrupt line and with two platform signals. The guest external line is picked from a vector by a selector field. The platform signals are a VS timer request and a VS external request.

The injection register is not an alias of the combined view. Its timer and external bits are private storage, and platform or guest-external activity never shows up when it is read. The software bit is the one exception. It is a single storage bit that both the injection register and the machine pending register write and read.

Writes arrive over a simple CSR port (address, data, enable) and take effect at the next clock edge. Both outputs are combinational from the stored bits and the input lines.

Top module: `vsip_top`

## Requirements
- R1: While reset is asserted, and after it is released with all input lines low, `inj_rdata` and `pend_view` read zero.
- R2: A write to the injection address (`INJ_ADDR`) stores bit 6 (VS timer), bit 10 (VS external) and bit 2 (VS software) of the write data. Every other bit of `inj_rdata` always reads zero, so writing all ones reads back as 0x444.
- R3: The VS software bit is one storage bit. It can be written at the injection address or at the machine pending address (`MPEND_ADDR`), and it reads the same at bit 2 of `inj_rdata` and bit 2 of `pend_view`.
- R4: Bit 10 of `pend_view` is the OR of three sources: the stored external bit, the selected guest external line, and `plat_vs_ext`.
- R5: Bit 6 of `pend_view` is the OR of the stored timer bit and `plat_vs_tmr`.
- R6: `inj_rdata` never reflects `plat_vs_ext`, `plat_vs_tmr`, `gext_pend` or `gext_sel`.
- R7: A selector value of 0, or a value above `GE_LINES`, selects no line and contributes zero. Bit 0 of `gext_pend` never contributes.
- R8: A write takes effect at the clock edge that samples `csr_we` high. During the write cycle both outputs still show the old stored value.
- R9: With `csr_we` low, or with an address that matches neither register, the stored bits do not change.
- R10: A write at the machine pending address changes only the software bit. The stored timer and external bits keep their value whatever bits 6 and 10 of the write data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | ADDR_W | CSR write address |
| csr_wdata | input | XLEN | CSR write data |
| gext_pend | input | GE_LINES+1 | Guest external pending lines; bit 0 is unused |
| gext_sel | input | SEL_W | Guest external line selector |
| plat_vs_ext | input | 1 | Platform VS external interrupt request |
| plat_vs_tmr | input | 1 | Platform VS timer interrupt request |
| inj_rdata | output | XLEN | Read value of the injection register |
| pend_view | output | XLEN | VS bits (2, 6, 10) of the combined pending view |

## Verification
A write and a change on the merge inputs can happen in the same cycle. For example, the injected timer bit can be cleared while `plat_vs_tmr` rises, or the software bit can be written at the machine address while the selector moves.

The bench drives all inputs together every cycle, both in directed steps and in a long random run. It samples both outputs one time unit after the drive, before the edge. It then compares them with a behavioural model. That model applies the write only after the edge and evaluates the merge from the current lines, so it catches a write that lands early and a platform level that leaks into the injection read.

// File: rtl/vsip_pkg.sv
package vsip_pkg;

    // Bit positions of the VS-level pending bits; other CSRs decode these.
    localparam int VS_SW_BIT  = 2;
    localparam int VS_TMR_BIT = 6;
    localparam int VS_EXT_BIT = 10;

    typedef struct packed {
        logic ext;
        logic tmr;
        logic sw;
    } vs_bits_t;

endpackage

// File: rtl/vsip_addr_decode.sv
module vsip_addr_decode #(
    parameter int               ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] INJ_ADDR   = 12'h645,
    parameter logic [ADDR_W-1:0] MPEND_ADDR = 12'h344
) (
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    output logic              inj_wr,
    output logic              mpend_wr
);

    always_comb begin
        inj_wr   = csr_we && (csr_addr == INJ_ADDR);
        mpend_wr = csr_we && (csr_addr == MPEND_ADDR);
    end

endmodule

// File: rtl/vsip_gext_select.sv
module vsip_gext_select #(
    parameter int GE_LINES = 8,
    parameter int SEL_W    = 4
) (
    input  logic [GE_LINES:0]  gext_pend,
    input  logic [SEL_W-1:0]   gext_sel,
    output logic               gext_hit
);

    logic [GE_LINES:0] line_hit;
    logic              pend0_unused;

    // Line 0 never exists; selector 0 therefore selects nothing.
    assign line_hit[0]  = 1'b0;
    assign pend0_unused = gext_pend[0];

    for (genvar i = 1; i <= GE_LINES; i++) begin : g_line
        assign line_hit[i] = gext_pend[i] && (gext_sel == SEL_W'(i));
    end

    assign gext_hit = |line_hit;

endmodule

// File: rtl/vsip_state.sv
module vsip_state
    import vsip_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     inj_wr,
    input  logic     mpend_wr,
    input  vs_bits_t wr_bits,
    output vs_bits_t held_q
);

    vs_bits_t held_d;

    always_comb begin
        held_d = held_q;
        if (inj_wr) begin
            held_d = wr_bits;
        end else if (mpend_wr) begin
            held_d.sw = wr_bits.sw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    // R10
    mpend_keeps_private_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mpend_wr && !inj_wr) |=> ($stable(held_q.tmr) && $stable(held_q.ext)));

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inj_wr && !mpend_wr) |=> $stable(held_q));

endmodule

// File: rtl/vsip_top.sv
module vsip_top
    import vsip_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter int               ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] INJ_ADDR   = 12'h645,
    parameter logic [ADDR_W-1:0] MPEND_ADDR = 12'h344,
    parameter int               GE_LINES   = 8,
    parameter int               SEL_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [GE_LINES:0] gext_pend,
    input  logic [SEL_W-1:0]  gext_sel,
    input  logic              plat_vs_ext,
    input  logic              plat_vs_tmr,
    output logic [XLEN-1:0]   inj_rdata,
    output logic [XLEN-1:0]   pend_view
);

    logic     inj_wr;
    logic     mpend_wr;
    logic     gext_hit;
    vs_bits_t wr_bits;
    vs_bits_t held_q;
    logic     wdata_unused;

    assign wr_bits.sw   = csr_wdata[VS_SW_BIT];
    assign wr_bits.tmr  = csr_wdata[VS_TMR_BIT];
    assign wr_bits.ext  = csr_wdata[VS_EXT_BIT];
    assign wdata_unused = ^csr_wdata;

    vsip_addr_decode #(
        .ADDR_W    (ADDR_W),
        .INJ_ADDR  (INJ_ADDR),
        .MPEND_ADDR(MPEND_ADDR)
    ) u_dec (
        .csr_we  (csr_we),
        .csr_addr(csr_addr),
        .inj_wr  (inj_wr),
        .mpend_wr(mpend_wr)
    );

    vsip_gext_select #(
        .GE_LINES(GE_LINES),
        .SEL_W   (SEL_W)
    ) u_gsel (
        .gext_pend(gext_pend),
        .gext_sel (gext_sel),
        .gext_hit (gext_hit)
    );

    vsip_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .inj_wr  (inj_wr),
        .mpend_wr(mpend_wr),
        .wr_bits (wr_bits),
        .held_q  (held_q)
    );

    always_comb begin
        inj_rdata = '0;
        inj_rdata[VS_SW_BIT]  = held_q.sw;
        inj_rdata[VS_TMR_BIT] = held_q.tmr;
        inj_rdata[VS_EXT_BIT] = held_q.ext;

        pend_view = '0;
        pend_view[VS_SW_BIT]  = held_q.sw;
        pend_view[VS_TMR_BIT] = held_q.tmr || plat_vs_tmr;
        pend_view[VS_EXT_BIT] = held_q.ext || gext_hit || plat_vs_ext;
    end

    // R3
    sw_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_rdata[VS_SW_BIT] == pend_view[VS_SW_BIT]);

    // R4
    plat_ext_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plat_vs_ext |-> pend_view[VS_EXT_BIT]);

    // R5
    plat_tmr_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plat_vs_tmr |-> pend_view[VS_TMR_BIT]);

    // R8
    inj_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == INJ_ADDR) |=>
            (inj_rdata[VS_EXT_BIT] == $past(csr_wdata[VS_EXT_BIT]) &&
             inj_rdata[VS_TMR_BIT] == $past(csr_wdata[VS_TMR_BIT])));

    // R6
    inj_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_we) |=> $stable(inj_rdata));

endmodule

// File: tb/vsip_top_tb.sv
module vsip_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int GE   = 8;
    localparam int SW   = 4;
    localparam logic [11:0] INJ = 12'h645;
    localparam logic [11:0] MP  = 12'h344;
    localparam logic [11:0] OTH = 12'h100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_we = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [GE:0]     gext_pend = '0;
    logic [SW-1:0]   gext_sel = '0;
    logic            plat_vs_ext = 1'b0;
    logic            plat_vs_tmr = 1'b0;
    logic [XLEN-1:0] inj_rdata;
    logic [XLEN-1:0] pend_view;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model state
    int m_sw  = 0;
    int m_tmr = 0;
    int m_ext = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsip_top #(
        .XLEN(XLEN), .ADDR_W(12), .INJ_ADDR(INJ), .MPEND_ADDR(MP),
        .GE_LINES(GE), .SEL_W(SW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .gext_pend(gext_pend), .gext_sel(gext_sel),
        .plat_vs_ext(plat_vs_ext), .plat_vs_tmr(plat_vs_tmr),
        .inj_rdata(inj_rdata), .pend_view(pend_view)
    );

    task automatic chk(input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int gsel_model(input logic [GE:0] g, input logic [SW-1:0] s);
        int idx = int'(s);
        if (idx >= 1 && idx <= GE) return int'(g[idx]);
        return 0;
    endfunction

    task automatic step(input logic we, input logic [11:0] a, input logic [XLEN-1:0] wd,
                        input logic [GE:0] g, input logic [SW-1:0] s,
                        input logic pe, input logic pt);
        logic [XLEN-1:0] e_inj;
        logic [XLEN-1:0] e_view;
        @(negedge clk);
        csr_we = we; csr_addr = a; csr_wdata = wd;
        gext_pend = g; gext_sel = s; plat_vs_ext = pe; plat_vs_tmr = pt;
        #1;
        e_inj = (XLEN'(m_sw) << 2) | (XLEN'(m_tmr) << 6) | (XLEN'(m_ext) << 10);
        e_view = (XLEN'(m_sw) << 2)
               | (XLEN'(m_tmr | int'(pt)) << 6)
               | (XLEN'(m_ext | gsel_model(g, s) | int'(pe)) << 10);
        chk("R2 R6 R8 injection read vs model", inj_rdata, e_inj);
        chk("R3 R4 R5 R8 pending view vs model", pend_view, e_view);
        @(posedge clk);
        if (we && a == INJ) begin
            m_sw = int'(wd[2]); m_tmr = int'(wd[6]); m_ext = int'(wd[10]);
        end else if (we && a == MP) begin
            m_sw = int'(wd[2]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 inj during reset", inj_rdata, '0);
        chk("R1 view during reset", pend_view, '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 inj after reset", inj_rdata, '0);
        chk("R1 view after reset", pend_view, '0);

        // R2 R8: all-ones write, old value visible during the write cycle
        step(1'b1, INJ, '1, '0, '0, 1'b0, 1'b0);
        #1;
        chk("R2 R8 all ones lands as 0x444", inj_rdata, 32'h444);

        // R3 R10: clear software bit through machine address
        step(1'b1, MP, 32'h0, '0, '0, 1'b0, 1'b0);
        #1;
        chk("R3 R10 machine write clears only sw", inj_rdata, 32'h440);
        chk("R3 R10 view after machine write", pend_view, 32'h440);

        // R9: disabled write and foreign address
        step(1'b0, INJ, 32'h0, '0, '0, 1'b0, 1'b0);
        #1;
        chk("R9 we low ignored", inj_rdata, 32'h440);
        step(1'b1, OTH, 32'h0, '0, '0, 1'b0, 1'b0);
        #1;
        chk("R9 other address ignored", inj_rdata, 32'h440);

        // R3: set sw through machine address, read via injection
        step(1'b1, INJ, 32'h0, '0, '0, 1'b0, 1'b0);
        step(1'b1, MP, 32'h444, '0, '0, 1'b0, 1'b0);
        #1;
        chk("R3 R10 machine sets sw only", inj_rdata, 32'h004);
        chk("R3 view sw", pend_view, 32'h004);
        step(1'b1, INJ, 32'h0, '0, '0, 1'b0, 1'b0);

        // R7 R6: guest external selection
        step(1'b0, OTH, 32'h0, 9'h1FF, 4'd0, 1'b0, 1'b0);
        chk("R7 selector zero", pend_view, 32'h0);
        step(1'b0, OTH, 32'h0, 9'h1FF, 4'd9, 1'b0, 1'b0);
        chk("R7 selector above range", pend_view, 32'h0);
        step(1'b0, OTH, 32'h0, 9'h001, 4'd0, 1'b0, 1'b0);
        chk("R7 line zero ignored", pend_view, 32'h0);
        step(1'b0, OTH, 32'h0, 9'h1FF, 4'd3, 1'b0, 1'b0);
        chk("R4 selected line merges", pend_view, 32'h400);
        chk("R6 guest line hidden from injection", inj_rdata, 32'h0);
        step(1'b0, OTH, 32'h0, 9'h100, 4'd8, 1'b0, 1'b0);
        chk("R7 top line selectable", pend_view, 32'h400);

        // R4 R5 R6: platform signals
        step(1'b0, OTH, 32'h0, '0, '0, 1'b0, 1'b1);
        chk("R5 platform timer merges", pend_view, 32'h040);
        chk("R6 platform timer hidden", inj_rdata, 32'h0);
        step(1'b0, OTH, 32'h0, '0, '0, 1'b1, 1'b0);
        chk("R4 platform ext merges", pend_view, 32'h400);
        chk("R6 platform ext hidden", inj_rdata, 32'h0);

        // same-cycle collisions: writes while merge inputs move
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            int pick = int'($urandom % 4);
            a = (pick == 0) ? INJ : (pick == 1) ? MP : (pick == 2) ? OTH : INJ;
            step(1'($urandom), a, XLEN'($urandom), (GE+1)'($urandom), SW'($urandom),
                 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule